// File: doc/BRIEF.md
# L3 Control Bus Master

This block drives a three-wire L3 control bus from a fast system clock. The three wires are a mode line, a bus clock and a serial data line. A host hands over bytes one at a time on a valid/ready command port. Each byte carries two flags. The first marks it as an address byte. The second marks it as the final byte of a transaction. The block shifts each byte out least significant bit first. It produces the bus clock and moves the mode line so that a receiver can tell the address phase from the data phase.

An address byte is sent with the mode line low and a data byte with it high. Between two data bytes of one transaction the mode line drops low for one half period and then returns high. An address byte that arrives while the data phase is still open starts a new address phase. A half-period input sets the bus clock rate in system clocks. Values below two are raised to two. The value is latched each time a command is accepted.

Top module: `l3_master`

## Requirements
- R1: After reset the bus is idle: `l3_mode` and `l3_clk` are high, `busy` is low and `cmd_ready` is high.
- R2: A byte accepted with `cmd_is_addr`=1 is shifted with `l3_mode` low at every falling edge of `l3_clk` for that byte.
- R3: With H = max(`half_period`, 2), every low period of `l3_clk` lasts exactly H system clocks. Every high period between two bits of the same byte also lasts exactly H system clocks.
- R4: The bit at falling edge k (k = 0..7) of a byte is bit k of the accepted `cmd_byte`, so the byte goes out least significant bit first.
- R5: A byte accepted with `cmd_is_addr`=0 is shifted with `l3_mode` high at every falling edge of `l3_clk` for that byte.
- R6: After a data byte with `cmd_last`=0, `l3_mode` goes low for exactly H system clocks with no `l3_clk` edge, then returns high. No such pulse follows an address byte, and none follows a byte with `cmd_last`=1.
- R7: `cmd_ready` is low whenever `l3_clk` is low. A command presented while `cmd_ready` is low is held until it is accepted, and it is then sent exactly once.
- R8: Whenever `busy` is low, both `l3_mode` and `l3_clk` are high. `busy` returns low after the byte with `cmd_last`=1 has finished.
- R9: An address byte accepted during an open data phase, after a strobe, starts a new address phase with `l3_mode` low. The data bytes that follow it are sent normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| half_period | input | DIV_W | Bus clock half period in system clocks (minimum 2 applied) |
| cmd_valid | input | 1 | Host presents a byte |
| cmd_ready | output | 1 | Block can take a byte this cycle |
| cmd_byte | input | 8 | Byte to send |
| cmd_is_addr | input | 1 | Byte is an address byte |
| cmd_last | input | 1 | Byte ends the transaction |
| busy | output | 1 | A transaction is in progress |
| l3_mode | output | 1 | Bus mode line |
| l3_clk | output | 1 | Bus clock line |
| l3_data | output | 1 | Bus data line |

## Verification
Two events can fall in the same cycle: the host presenting its next byte, and the block closing the previous one, either at the end of the strobe or at the end of the final high half period. The bench sometimes issues the next command at once, so `cmd_valid` is held high while the block is still shifting. Acceptance then lands in the first cycle in which `cmd_ready` rises. A bus decoder rebuilds every byte and every strobe from the three wires and compares them in order with the expected event list. This comparison shows whether a held command was lost, sent twice, or merged into the previous byte's timing.

// File: rtl/l3_master.sv
module l3_master #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] half_period,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [7:0]       cmd_byte,
  input  logic             cmd_is_addr,
  input  logic             cmd_last,
  output logic             busy,
  output logic             l3_mode,
  output logic             l3_clk,
  output logic             l3_data
);

  localparam logic [DIV_W-1:0] MIN_H = DIV_W'(2);

  typedef enum logic [2:0] {
    S_IDLE, S_SETUP, S_HI, S_LO, S_POST, S_STROBE, S_WAIT
  } state_t;

  state_t           state;
  logic [DIV_W-1:0] cnt, hreg;
  logic [7:0]       sh;
  logic [2:0]       bitn;
  logic             mode_r, last_r, addr_r;

  wire [DIV_W-1:0] h_eff  = (half_period < MIN_H) ? MIN_H : half_period;
  wire             tick   = (cnt == '0);
  wire             accept = cmd_valid && cmd_ready;

  assign cmd_ready = (state == S_IDLE) || (state == S_WAIT);
  assign busy      = (state != S_IDLE);
  assign l3_clk    = (state != S_LO);
  assign l3_data   = sh[0];
  assign l3_mode   = mode_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      cnt    <= '0;
      hreg   <= MIN_H;
      sh     <= '0;
      bitn   <= '0;
      mode_r <= 1'b1;
      last_r <= 1'b0;
      addr_r <= 1'b0;
    end else begin
      case (state)
        S_IDLE, S_WAIT: begin
          if (accept) begin
            state  <= S_SETUP;
            sh     <= cmd_byte;
            addr_r <= cmd_is_addr;
            last_r <= cmd_last;
            mode_r <= !cmd_is_addr;
            bitn   <= '0;
            hreg   <= h_eff;
            cnt    <= h_eff - 1'b1;
          end
        end
        S_SETUP, S_HI: begin
          if (tick) begin
            state <= S_LO;
            cnt   <= hreg - 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_LO: begin
          if (tick) begin
            sh    <= sh >> 1;
            bitn  <= bitn + 3'd1;
            state <= (bitn == 3'd7) ? S_POST : S_HI;
            cnt   <= hreg - 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_POST: begin
          if (tick) begin
            cnt <= hreg - 1'b1;
            if (last_r) begin
              state  <= S_IDLE;
              mode_r <= 1'b1;
            end else if (!addr_r) begin
              state  <= S_STROBE;
              mode_r <= 1'b0;
            end else begin
              state  <= S_WAIT;
              mode_r <= 1'b1;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_STROBE: begin
          if (tick) begin
            state  <= S_WAIT;
            mode_r <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (l3_mode && l3_clk)); // R8
  AST_NO_READY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !l3_clk |-> !cmd_ready); // R7
  AST_LOW_MIN_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(l3_clk) |=> !l3_clk); // R3
  AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!l3_clk && $past(!l3_clk)) |-> $stable(l3_data)); // R4
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!l3_clk && $past(!l3_clk)) |-> $stable(l3_mode)); // R2

endmodule

// File: tb/l3_master_tb.sv
module l3_master_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] half_period = 8'd3;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [7:0] cmd_byte = '0;
  logic       cmd_is_addr = 1'b0;
  logic       cmd_last = 1'b0;
  logic       busy, l3_mode, l3_clk, l3_data;

  always #4 clk = ~clk;

  l3_master #(.DIV_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .half_period(half_period),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_byte(cmd_byte),
    .cmd_is_addr(cmd_is_addr), .cmd_last(cmd_last), .busy(busy),
    .l3_mode(l3_mode), .l3_clk(l3_clk), .l3_data(l3_data)
  );

  int total = 0, bad = 0;
  int cur_h = 3;
  int held_cycles = 0;
  bit done = 0;

  bit       exp_k [0:2047];
  bit       exp_m [0:2047];
  bit [7:0] exp_b [0:2047];
  int       n_exp = 0;
  bit       got_k [0:2047];
  bit       got_m [0:2047];
  bit [7:0] got_b [0:2047];
  int       n_got = 0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic int heff(input int hp);
    return (hp < 2) ? 2 : hp;
  endfunction

  function automatic bit [7:0] mk_addr(input bit [1:0] ty);
    return {6'b000101, ty};
  endfunction

  task automatic push_exp(input bit k, input bit m, input bit [7:0] b);
    exp_k[n_exp] = k; exp_m[n_exp] = m; exp_b[n_exp] = b; n_exp++;
  endtask

  task automatic send(input bit [7:0] b, input bit a, input bit l);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_byte = b; cmd_is_addr = a; cmd_last = l;
    while (!cmd_ready) begin
      held_cycles++;
      @(negedge clk);
    end
    @(posedge clk);
    push_exp(1'b0, !a, b);
    if (!l && !a) push_exp(1'b1, 1'b1, 8'h00);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic txn(input bit [1:0] ty, input int n, input bit gaps);
    send(mk_addr(ty), 1'b1, 1'b0);
    for (int i = 0; i < n; i++) begin
      if (gaps) repeat ($urandom_range(0, 3)) @(negedge clk);
      send(8'($urandom), 1'b0, i == n - 1);
    end
    wait_idle();
  endtask

  task automatic set_h(input int hp);
    half_period = 8'(hp);
    cur_h = heff(hp);
  endtask

  bit       pclk, pmode, fell_seen;
  int       crun, mrun, bitpos;
  bit       bmode;
  bit [7:0] shb;

  always @(negedge clk) begin
    if (!rst_n) begin
      pclk = 1; pmode = 1; fell_seen = 0; crun = 0; mrun = 0; bitpos = 0; shb = 0; bmode = 0;
    end else begin
      if (!busy) chk(l3_mode && l3_clk, "R8 idle lines", {l3_mode, l3_clk}, 3);
      if (!l3_clk) chk(!cmd_ready, "R7 ready while clock low", cmd_ready, 0);
      if (l3_clk != pclk) begin
        if (!l3_clk) begin
          if (bitpos != 0) chk(crun == cur_h, "R3 high period", crun, cur_h);
          if (bitpos == 0) bmode = l3_mode;
          else chk(l3_mode == bmode, "R2/R5 mode within byte", l3_mode, bmode);
          shb[bitpos] = l3_data;
          fell_seen = 1;
          if (bitpos == 7) begin
            got_k[n_got] = 0; got_m[n_got] = bmode; got_b[n_got] = shb; n_got++;
            bitpos = 0;
          end else bitpos++;
        end else begin
          chk(crun == cur_h, "R3 low period", crun, cur_h);
        end
        crun = 1;
      end else crun++;
      if (l3_mode != pmode) begin
        if (l3_mode && !fell_seen) begin
          chk(mrun == cur_h, "R6 strobe width", mrun, cur_h);
          got_k[n_got] = 1; got_m[n_got] = 1; got_b[n_got] = 0; n_got++;
        end
        if (!l3_mode) fell_seen = 0;
        mrun = 1;
      end else mrun++;
      pclk = l3_clk; pmode = l3_mode;
    end
  end

  task automatic compare_events(input string tag);
    chk(n_got == n_exp, tag, n_got, n_exp);
    for (int i = 0; i < n_exp && i < n_got; i++) begin
      chk(got_k[i] == exp_k[i], "R6 event kind", got_k[i], exp_k[i]);
      if (!exp_k[i]) begin
        chk(got_b[i] == exp_b[i], "R4 byte value", got_b[i], exp_b[i]);
        chk(got_m[i] == exp_m[i], exp_m[i] ? "R5 data mode" : "R2 address mode", got_m[i], exp_m[i]);
      end
    end
    n_got = 0; n_exp = 0;
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "WATCHDOG", 0, 1);
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(l3_mode == 1, "R1 mode idle", l3_mode, 1);
    chk(l3_clk == 1, "R1 clock idle", l3_clk, 1);
    chk(busy == 0, "R1 busy idle", busy, 0);
    chk(cmd_ready == 1, "R1 ready idle", cmd_ready, 1);

    set_h(3);
    txn(2'b10, 1, 1'b0);
    compare_events("R2 status write events");

    set_h(0);
    txn(2'b00, 4, 1'b0);
    compare_events("R3 minimum half period clamp 0");

    set_h(1);
    txn(2'b00, 4, 1'b1);
    compare_events("R3 minimum half period clamp 1");

    set_h(7);
    send(8'hA5, 1'b0, 1'b1);
    wait_idle();
    compare_events("R5 lone data byte");

    set_h(2);
    send(mk_addr(2'b00), 1'b1, 1'b0);
    send(8'h3C, 1'b0, 1'b0);
    send(mk_addr(2'b10), 1'b1, 1'b0);
    send(8'h81, 1'b0, 1'b1);
    wait_idle();
    chk(n_exp == 5, "R9 expected sequence length", n_exp, 5);
    compare_events("R9 new address in data phase");

    for (int t = 0; t < 30; t++) begin
      set_h($urandom_range(0, 6));
      txn(($urandom_range(0, 1) != 0) ? 2'b10 : 2'b00,
          ($urandom_range(0, 1) != 0) ? 1 : 4, ($urandom_range(0, 1) != 0));
      compare_events("R7 random transaction");
    end

    chk(held_cycles > 0, "R7 hold-off provoked", held_cycles, 1);
    @(negedge clk);
    chk(!busy && l3_mode && l3_clk, "R8 final idle", {busy, l3_mode, l3_clk}, 3);
    done = 1;
    finish_run();
  end
endmodule